// File: doc/BRIEF.md
# Debug Mailbox with Status Word

This block is a two-way message channel between an external debug host and a processor core. The host deposits a word into a receive mailbox, and the core picks it up as two half-words. In the other direction the core fills a transmit mailbox as two half-words, and the host collects the whole word. Two flags record whether each mailbox holds unread data.

A read-only status word gives the core both flags. It also reports a two-bit code for the processing state of the core, and a flag that marks an execution set aborted by a pending exception. The state code is also loaded into a capture register on the host side. The host can therefore poll it without a core read, for example while core software has stopped its clock.

The core reaches the block through a small register port that returns data one cycle after a read. The host side uses single-cycle completion strobes that are already synchronised to the block clock.

Top module: `dbg_mailbox`

## Requirements
- R1: After a synchronous reset, every flag is 0, the transmit word is 0, the host capture is 0, and a status read returns 0 while all state inputs are low.
- R2: The state code, registered one cycle after its inputs, is 2'b10 (bus wait) whenever `bus_stall` or `ext_disable` is high. Otherwise it is 2'b11 when `dbg_active` is high, 2'b01 when `wait_stop` is high, and 2'b00 (executing) when none of them is high.
- R3: On a cycle with `h_capture` high, `h_state_cap` loads the registered state code. On every other cycle it holds its value.
- R4: `h_rx_wr_done` sets the receive-full flag and captures `h_rx_data` into the receive mailbox.
- R5: A core read at address 1 (upper half) clears receive-full, whether or not address 0 (lower half) was read first. A read at address 0 leaves the flag unchanged.
- R6: A core write at address 1 sets transmit-full and publishes {upper, last lower half} on `h_tx_data`, whether or not address 0 was written first. A write at address 0 alone leaves the flag unchanged.
- R7: `h_tx_rd_done` clears transmit-full.
- R8: `exec_abort` sets the killed flag and `step_start` clears it.
- R9: For every flag, a set event and a clear event in the same cycle leave the flag set.
- R10: A status read (address 2) returns the state code in bits 31:30, 0 at bit 29, killed at bit 28, receive-full at bit 27, transmit-full at bit 26, and 0 in bits 25:0. A status read changes no state.
- R11: While a mailbox is full, new data from its producer is ignored, unless the consumer completes its access in the same cycle.
- R12: A core read returns its data on `c_rdata` on the clock after `c_rd`. A half-word read is zero-extended, and address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| h_rx_data | input | 32 | Word the host writes into the receive mailbox |
| h_rx_wr_done | input | 1 | Pulse: host has completed its mailbox write |
| h_tx_data | output | 32 | Transmit mailbox word seen by the host |
| h_tx_rd_done | input | 1 | Pulse: host has completed its mailbox read |
| h_capture | input | 1 | Load the state code into the host capture register |
| h_state_cap | output | 2 | Host-side copy of the state code |
| c_rd | input | 1 | Core read strobe |
| c_wr | input | 1 | Core write strobe |
| c_addr | input | 2 | Core register address |
| c_wdata | input | 16 | Core write half-word |
| c_rdata | output | 32 | Core read data, registered |
| dbg_active | input | 1 | Core is in debug state |
| wait_stop | input | 1 | Core is in wait or stop mode |
| bus_stall | input | 1 | Core is stalled on a bus transfer |
| ext_disable | input | 1 | Core is disabled by the system |
| exec_abort | input | 1 | Pulse: last execution set was aborted |
| step_start | input | 1 | Pulse: a single step begins |

## Verification
The bench builds the block with its default widths: 16-bit halves and a 32-bit status word. These widths put the flag bits at 27 and 26 and the state code at 31:30, so the status layout is checked against fixed bit positions. Every read of a half-word or the status word passes through the scoreboard, which brings into reach the upper-half-only access, ignored writes while a mailbox is full, and same-cycle set and clear on every flag.

// File: rtl/dbg_mbx_pkg.sv
package dbg_mbx_pkg;
  typedef enum logic [1:0] {
    CS_EXEC  = 2'b00,
    CS_WAIT  = 2'b01,
    CS_BUS   = 2'b10,
    CS_DEBUG = 2'b11
  } core_state_e;

  localparam logic [1:0] A_RX_LO  = 2'd0;
  localparam logic [1:0] A_RX_HI  = 2'd1;
  localparam logic [1:0] A_STATUS = 2'd2;
  localparam logic [1:0] A_TX_LO  = 2'd0;
  localparam logic [1:0] A_TX_HI  = 2'd1;
endpackage

// File: rtl/mbx_rx.sv
module mbx_rx #(
  parameter int HW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            h_wr_done,
  input  logic [2*HW-1:0] h_data,
  input  logic            rd_hi,
  output logic            full,
  output logic [2*HW-1:0] word
);
  logic take;
  assign take = h_wr_done && (!full || rd_hi);

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      word <= '0;
    end else begin
      if (take) word <= h_data;
      if (h_wr_done)  full <= 1'b1;
      else if (rd_hi) full <= 1'b0;
    end
  end
endmodule

// File: rtl/mbx_tx.sv
module mbx_tx #(
  parameter int HW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [HW-1:0]   wdata,
  input  logic            h_rd_done,
  output logic            full,
  output logic [2*HW-1:0] word
);
  logic          accept;
  logic [HW-1:0] lo_stage;
  assign accept = !full || h_rd_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      full     <= 1'b0;
      word     <= '0;
      lo_stage <= '0;
    end else begin
      if (wr_lo && accept) lo_stage <= wdata;
      if (wr_hi && accept) word <= {wdata, lo_stage};
      if (wr_hi && accept) full <= 1'b1;
      else if (h_rd_done)  full <= 1'b0;
    end
  end
endmodule

// File: rtl/core_state_trk.sv
module core_state_trk
  import dbg_mbx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        dbg_active,
  input  logic        wait_stop,
  input  logic        bus_stall,
  input  logic        ext_disable,
  input  logic        exec_abort,
  input  logic        step_start,
  input  logic        capture,
  output core_state_e cstate,
  output logic        killed,
  output logic [1:0]  cap
);
  core_state_e next_state;

  always_comb begin
    if (bus_stall || ext_disable) next_state = CS_BUS;
    else if (dbg_active)          next_state = CS_DEBUG;
    else if (wait_stop)           next_state = CS_WAIT;
    else                          next_state = CS_EXEC;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cstate <= CS_EXEC;
      killed <= 1'b0;
      cap    <= 2'b00;
    end else begin
      cstate <= next_state;
      if (exec_abort)      killed <= 1'b1;
      else if (step_start) killed <= 1'b0;
      if (capture) cap <= cstate;
    end
  end
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
  import dbg_mbx_pkg::*;
#(
  parameter int HW     = 16,
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2*HW-1:0]   h_rx_data,
  input  logic              h_rx_wr_done,
  output logic [2*HW-1:0]   h_tx_data,
  input  logic              h_tx_rd_done,
  input  logic              h_capture,
  output logic [1:0]        h_state_cap,
  input  logic              c_rd,
  input  logic              c_wr,
  input  logic [1:0]        c_addr,
  input  logic [HW-1:0]     c_wdata,
  output logic [STAT_W-1:0] c_rdata,
  input  logic              dbg_active,
  input  logic              wait_stop,
  input  logic              bus_stall,
  input  logic              ext_disable,
  input  logic              exec_abort,
  input  logic              step_start
);
  localparam int POS_KILL = STAT_W - 4;
  localparam int POS_RX   = STAT_W - 5;
  localparam int POS_TX   = STAT_W - 6;
  localparam int PAD_W    = STAT_W - HW;

  logic            rd_rx_hi, wr_tx_lo, wr_tx_hi;
  logic            rx_full, tx_full, killed;
  logic [2*HW-1:0] rx_word;
  core_state_e     cstate;
  logic [STAT_W-1:0] status;

  assign rd_rx_hi = c_rd && (c_addr == A_RX_HI);
  assign wr_tx_lo = c_wr && (c_addr == A_TX_LO);
  assign wr_tx_hi = c_wr && (c_addr == A_TX_HI);

  mbx_rx #(.HW(HW)) u_rx (
    .clk(clk), .rst(rst), .h_wr_done(h_rx_wr_done), .h_data(h_rx_data),
    .rd_hi(rd_rx_hi), .full(rx_full), .word(rx_word)
  );

  mbx_tx #(.HW(HW)) u_tx (
    .clk(clk), .rst(rst), .wr_lo(wr_tx_lo), .wr_hi(wr_tx_hi), .wdata(c_wdata),
    .h_rd_done(h_tx_rd_done), .full(tx_full), .word(h_tx_data)
  );

  core_state_trk u_state (
    .clk(clk), .rst(rst), .dbg_active(dbg_active), .wait_stop(wait_stop),
    .bus_stall(bus_stall), .ext_disable(ext_disable), .exec_abort(exec_abort),
    .step_start(step_start), .capture(h_capture), .cstate(cstate),
    .killed(killed), .cap(h_state_cap)
  );

  always_comb begin
    status                  = '0;
    status[STAT_W-1 -: 2]   = cstate;
    status[POS_KILL]        = killed;
    status[POS_RX]          = rx_full;
    status[POS_TX]          = tx_full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c_rdata <= '0;
    end else if (c_rd) begin
      case (c_addr)
        A_RX_LO:  c_rdata <= {{PAD_W{1'b0}}, rx_word[HW-1:0]};
        A_RX_HI:  c_rdata <= {{PAD_W{1'b0}}, rx_word[2*HW-1:HW]};
        A_STATUS: c_rdata <= status;
        default:  c_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dbg_mailbox_chk.sv
module dbg_mailbox_chk #(
  parameter int HW     = 16,
  parameter int STAT_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              h_rx_wr_done,
  input logic              h_tx_rd_done,
  input logic              h_capture,
  input logic [1:0]        h_state_cap,
  input logic              rd_rx_hi,
  input logic              wr_tx_hi,
  input logic              rx_full,
  input logic              tx_full,
  input logic              killed,
  input logic [1:0]        cstate,
  input logic [2*HW-1:0]   rx_word,
  input logic              bus_stall,
  input logic              ext_disable,
  input logic              exec_abort,
  input logic              c_rd,
  input logic [1:0]        c_addr,
  input logic [STAT_W-1:0] c_rdata
);
  p_rx_set_r4: assert property (@(posedge clk) disable iff (rst)
    h_rx_wr_done |=> rx_full);
  p_rx_clr_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_rx_hi && !h_rx_wr_done) |=> !rx_full);
  p_tx_set_r6: assert property (@(posedge clk) disable iff (rst)
    wr_tx_hi |=> tx_full);
  p_tx_clr_r7: assert property (@(posedge clk) disable iff (rst)
    (h_tx_rd_done && !wr_tx_hi) |=> !tx_full);
  p_bus_prio_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_stall || ext_disable) |=> (cstate == 2'b10));
  p_kill_set_r8: assert property (@(posedge clk) disable iff (rst)
    exec_abort |=> killed);
  p_rx_stable_r11: assert property (@(posedge clk) disable iff (rst)
    (rx_full && !rd_rx_hi) |=> $stable(rx_word));
  p_cap_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !h_capture |=> $stable(h_state_cap));
  p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (c_rd && c_addr == 2'd2) |=> (c_rdata[STAT_W-3] == 1'b0 && c_rdata[STAT_W-7:0] == '0));
endmodule

bind dbg_mailbox dbg_mailbox_chk #(.HW(HW), .STAT_W(STAT_W)) u_chk (
  .clk(clk), .rst(rst), .h_rx_wr_done(h_rx_wr_done), .h_tx_rd_done(h_tx_rd_done),
  .h_capture(h_capture), .h_state_cap(h_state_cap), .rd_rx_hi(rd_rx_hi),
  .wr_tx_hi(wr_tx_hi), .rx_full(rx_full), .tx_full(tx_full), .killed(killed),
  .cstate(cstate), .rx_word(rx_word), .bus_stall(bus_stall),
  .ext_disable(ext_disable), .exec_abort(exec_abort), .c_rd(c_rd),
  .c_addr(c_addr), .c_rdata(c_rdata)
);

// File: tb/dbg_mailbox_tb.sv
module dbg_mailbox_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] h_rx_data = '0;
  logic        h_rx_wr_done = 1'b0;
  logic [31:0] h_tx_data;
  logic        h_tx_rd_done = 1'b0;
  logic        h_capture = 1'b0;
  logic [1:0]  h_state_cap;
  logic        c_rd = 1'b0, c_wr = 1'b0;
  logic [1:0]  c_addr = '0;
  logic [15:0] c_wdata = '0;
  logic [31:0] c_rdata;
  logic        dbg_active = 0, wait_stop = 0, bus_stall = 0, ext_disable = 0;
  logic        exec_abort = 0, step_start = 0;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_d = 1'b0;

  logic [1:0] e_st = 2'b00;
  logic       e_k = 0, e_rx = 0, e_tx = 0;

  always #10 clk = ~clk;

  dbg_mailbox u_dut (
    .clk(clk), .rst(rst), .h_rx_data(h_rx_data), .h_rx_wr_done(h_rx_wr_done),
    .h_tx_data(h_tx_data), .h_tx_rd_done(h_tx_rd_done), .h_capture(h_capture),
    .h_state_cap(h_state_cap), .c_rd(c_rd), .c_wr(c_wr), .c_addr(c_addr),
    .c_wdata(c_wdata), .c_rdata(c_rdata), .dbg_active(dbg_active),
    .wait_stop(wait_stop), .bus_stall(bus_stall), .ext_disable(ext_disable),
    .exec_abort(exec_abort), .step_start(step_start)
  );

  function automatic logic [31:0] stat_word();
    return {e_st, 1'b0, e_k, e_rx, e_tx, 26'd0};
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare read data the cycle after each core read
  always @(posedge clk) rd_d <= c_rd && !rst;
  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL scoreboard: actual %h expected none", c_rdata);
      end else begin
        check(c_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  // driver tasks: all start and end at a falling edge
  task automatic core_rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    c_rd = 1; c_addr = a; exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); c_rd = 0;
  endtask
  task automatic rd_status(input string tag);
    core_rd(2'd2, stat_word(), tag);
  endtask
  task automatic core_wr(input logic [1:0] a, input logic [15:0] d);
    c_wr = 1; c_addr = a; c_wdata = d;
    @(negedge clk); c_wr = 0;
  endtask
  task automatic host_wr(input logic [31:0] d);
    h_rx_data = d; h_rx_wr_done = 1;
    @(negedge clk); h_rx_wr_done = 0;
  endtask
  task automatic host_rd();
    h_tx_rd_done = 1;
    @(negedge clk); h_tx_rd_done = 0;
  endtask
  task automatic tick();
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check({30'd0, h_state_cap}, 32'd0, "R1 capture");
    check(h_tx_data, 32'd0, "R1 tx word");
    rd_status("R1 status");
    core_rd(2'd3, 32'd0, "R12 addr3");

    // R2 state priority
    wait_stop = 1; tick(); e_st = 2'b01; rd_status("R2 wait");
    dbg_active = 1; tick(); e_st = 2'b11; rd_status("R2 debug over wait");
    bus_stall = 1; tick(); e_st = 2'b10; rd_status("R2 bus stall priority");
    bus_stall = 0; ext_disable = 1; tick(); rd_status("R2 ext disable priority");
    ext_disable = 0; tick(); e_st = 2'b11;
    // R3 capture
    h_capture = 1; tick(); h_capture = 0;
    check({30'd0, h_state_cap}, 32'd3, "R3 capture load");
    dbg_active = 0; wait_stop = 0; tick(); tick(); e_st = 2'b00;
    check({30'd0, h_state_cap}, 32'd3, "R3 capture hold");
    rd_status("R2 executing");
    h_capture = 1; tick(); h_capture = 0;
    check({30'd0, h_state_cap}, 32'd0, "R3 capture reload");

    // R4 / R5 / R12 receive path
    host_wr(32'hA5A5_1234); e_rx = 1; rd_status("R4 rx full set");
    core_rd(2'd0, 32'h0000_1234, "R12 rx lower");
    rd_status("R5 lower read keeps flag");
    core_rd(2'd1, 32'h0000_A5A5, "R12 rx upper");
    e_rx = 0; rd_status("R5 upper read clears");
    host_wr(32'h0F0F_7777); e_rx = 1;
    // R11: write while full ignored
    host_wr(32'hDEAD_BEEF);
    core_rd(2'd1, 32'h0000_0F0F, "R11 rx kept while full / R5 upper only");
    e_rx = 0; rd_status("R5 upper-only clears");
    // R9 rx: set and clear same cycle
    host_wr(32'h1111_2222); e_rx = 1;
    h_rx_data = 32'h3333_4444; h_rx_wr_done = 1;
    core_rd(2'd1, 32'h0000_1111, "R9 rx read during write");
    h_rx_wr_done = 0;
    rd_status("R9 rx set wins");
    core_rd(2'd0, 32'h0000_4444, "R9 rx new data taken");

    // R6 / R7 transmit path
    core_wr(2'd1, 16'hBEEF); e_tx = 1;
    check(h_tx_data, 32'hBEEF_0000, "R6 upper-only write");
    rd_status("R6 tx full set");
    host_rd(); e_tx = 0; rd_status("R7 tx clear");
    core_wr(2'd0, 16'h1111); rd_status("R6 lower write no flag");
    core_wr(2'd1, 16'h2222); e_tx = 1;
    check(h_tx_data, 32'h2222_1111, "R6 tx word");
    core_wr(2'd0, 16'h3333); core_wr(2'd1, 16'h4444);
    check(h_tx_data, 32'h2222_1111, "R11 tx kept while full");
    // R9 tx: write upper while host completes read
    h_tx_rd_done = 1; core_wr(2'd1, 16'h5555); h_tx_rd_done = 0;
    check(h_tx_data, 32'h5555_1111, "R9 tx accepted on read");
    rd_status("R9 tx set wins");

    // R8 killed flag
    exec_abort = 1; tick(); exec_abort = 0; e_k = 1; rd_status("R8 killed set");
    step_start = 1; tick(); step_start = 0; e_k = 0; rd_status("R8 killed clear");
    exec_abort = 1; step_start = 1; tick(); exec_abort = 0; step_start = 0; e_k = 1;
    rd_status("R9 killed set wins");

    // R10 full layout and read without side effects
    dbg_active = 1; host_wr(32'h0); e_rx = 1; e_st = 2'b11;
    rd_status("R10 layout");
    rd_status("R10 no side effect");
    tick(); tick();
    check(n_fail, 0, "R10 scoreboard clean"); n_chk--;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule